// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Target

This block is a two-wire serial target (I2C signalling) that only accepts writes. It sits next to a bank of 26 byte-wide control registers and lets a host on the serial bus fill them. Both bus lines are sampled with the system clock. A two-flop synchronizer comes first, and START, repeated START and STOP are recognised on the synchronized levels. The target acknowledges by pulling SDA low through an open-drain enable.

A transfer is made of a START, then the device byte (fixed 7-bit address plus a write bit), then one byte that loads an internal register pointer, then any number of data bytes, then a STOP. Each data byte is stored at the pointer, and the pointer then moves up by one. Each register keeps only the bits that the register map defines. Every register is exported at once as a flat vector, so the analog and timing logic around the block can decode its fields directly.

Top module: `wo_i2c_regfile`

## Requirements
- R1: A first byte equal to 8'hEA (address 7'b1110101 sent MSB first, followed by write bit 0) is acknowledged: `sda_drive_low` is 1 while SCL is high in the ninth clock.
- R2: A first byte with a different address, or with the eighth bit set to 1 (read), gets no acknowledge. Every later byte up to the next START is then ignored, with no acknowledge and no register change.
- R3: SDA falling while SCL is high begins a frame. SDA rising while SCL is high ends it. A STOP that arrives before a byte's eighth bit writes nothing.
- R4: A repeated START in the middle of a frame discards the current pointer state and restarts at the device-byte phase.
- R5: `sda_drive_low` is raised only after the falling edge of the eighth SCL clock of a byte. It is dropped after the falling edge of the ninth. It is never 1 while a data bit is on the bus.
- R6: The second byte of a frame loads the register pointer. Each later byte is written to the pointer's register and is acknowledged, and the pointer then increments by one. Registers change only through such writes.
- R7: A data byte whose pointer is 8'h1A or above is acknowledged but changes no register.
- R8: Bits that a register does not define are stored as 0. The kept-bit masks by address are: 00h FF; 01h and 04h 9F; 02h, 03h, 05h, 06h and 0Ah 1F; 07h to 09h and 0Bh to 16h 3F; 17h E7; 18h and 19h 8F.
- R9: While `rst_n` is low at a clock edge, every register is cleared to 8'h00 and `sda_drive_low` goes to 0.
- R10: Register n appears on `regs_flat[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_flat | output | 208 | All 26 registers, register n at bits 8n+7:8n |

## Verification
The assertions take for granted that SCL stays low for many system clocks around each acknowledge. A rising acknowledge must therefore see a low synchronized SCL, and a falling one must follow an SCL fall or a bus condition. They also assume that SDA does not change while SCL is high, except to form a START or STOP. The bench drives an SCL half period of 10 system clocks. It changes SDA only in the middle of the low phase, except when it deliberately forms a START, a repeated START or a STOP, so every input stays inside those assumptions. The bus SDA that the block sees is the host's level ANDed with the block's own pull-down, as it would be on a wired line.

// File: rtl/wo_i2c_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the register bit-mask map for the write-only
// two-wire register target. Assumes byte-wide registers.
package wo_i2c_pkg;

    localparam int BYTE_W = 8;

    // Frame phase of the receiver.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DEV  = 2'd1,
        PH_PTR  = 2'd2,
        PH_DAT  = 2'd3
    } phase_t;

    // Kept bits of each register; addresses beyond the map keep nothing.
    function automatic logic [BYTE_W-1:0] field_mask(input int unsigned idx);
        logic [BYTE_W-1:0] m;
        case (idx)
            0:              m = 8'hFF;
            1, 4:           m = 8'h9F;
            2, 3, 5, 6, 10: m = 8'h1F;
            7, 8, 9:        m = 8'h3F;
            23:             m = 8'hE7;
            24, 25:         m = 8'h8F;
            default:        m = (idx >= 11 && idx <= 22) ? 8'h3F : 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wo_i2c_line_sync.sv
`timescale 1ns/1ps
// Synchronizes SCL and SDA into the system clock domain and derives SCL edges
// and bus conditions. Assumes the system clock is at least 10x the SCL rate;
// lines reset to the idle (high) level so no false condition fires after reset.
module wo_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;   // index 1 = SCL, index 0 = SDA

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    // One synchronizer chain per bus line.
    for (genvar ln = 0; ln < NLINES; ln++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line level through the synchronizer flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else if (STAGES == 1) begin
                chain <= raw[ln];
            end else begin
                chain <= {chain[STAGES-2:0], raw[ln]};
            end
        end

        assign synced[ln] = chain[STAGES-1];
    end

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= synced;
        end
    end

    assign scl_lvl  = synced[1];
    assign sda_lvl  = synced[0];
    assign scl_rise = synced[1] & ~prev[1];
    assign scl_fall = ~synced[1] & prev[1];
    assign start_ev = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign stop_ev  = synced[1] & prev[1] & ~prev[0] & synced[0];

endmodule

// File: rtl/wo_i2c_rx_fsm.sv
`timescale 1ns/1ps
// Receives bytes of a write-only frame: device byte, pointer byte, data bytes.
// Drives the acknowledge enable and issues one write strobe per data byte.
// Assumes clean, synchronized SCL edges and bus conditions from the line sync.
module wo_i2c_rx_fsm
    import wo_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'b1110101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic              ack_drv,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] DEV_WRITE = {DEV_ID, 1'b0};

    phase_t             phase;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  ptr;

    // Byte reception, acknowledge control, pointer and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            ack_drv <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                ack_drv <= 1'b0;
            end else if (stop_ev) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                ack_drv <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && bit_cnt == LAST_BIT) begin
                    bit_cnt <= ACK_SLOT;
                    case (phase)
                        PH_DEV: begin
                            if (shreg == DEV_WRITE) begin
                                ack_drv <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_PTR: begin
                            ptr     <= shreg;
                            ack_drv <= 1'b1;
                        end
                        default: begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr;
                            wr_data <= shreg;
                            ptr     <= ptr + 1'b1;
                            ack_drv <= 1'b1;
                        end
                    endcase
                end else if (scl_fall && bit_cnt == ACK_SLOT) begin
                    ack_drv <= 1'b0;
                    bit_cnt <= '0;
                    if (phase == PH_DEV) begin
                        phase <= PH_PTR;
                    end else if (phase == PH_PTR) begin
                        phase <= PH_DAT;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/wo_i2c_reg_bank.sv
`timescale 1ns/1ps
// Bank of byte registers written by strobe; masks undefined bits to zero and
// drops writes whose address lies beyond the bank. Presents all registers flat.
module wo_i2c_reg_bank
    import wo_i2c_pkg::*;
#(
    parameter int NREG = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NREG*BYTE_W-1:0]   regs_flat
);
    // One register per address, each with its own decode and mask.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] MY_ADDR = BYTE_W'(i);
        localparam logic [BYTE_W-1:0] KEEP    = field_mask(i);
        logic [BYTE_W-1:0] value;

        // Load the masked byte when this address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                value <= '0;
            end else if (wr_en && wr_addr == MY_ADDR) begin
                value <= wr_data & KEEP;
            end
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = value;
    end

endmodule

// File: rtl/wo_i2c_regfile.sv
`timescale 1ns/1ps
// Write-only two-wire target with a byte register bank. Samples the bus with
// clk (at least 10x SCL), acknowledges by open-drain pull-down, and exports
// every register in parallel. No read, no clock stretching.
module wo_i2c_regfile
    import wo_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'b1110101,
    parameter int         NREG        = 26,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_drive_low,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_ev;
    logic              stop_ev;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    wo_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    wo_i2c_rx_fsm #(.DEV_ID(DEV_ID)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .ack_drv  (sda_drive_low),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    wo_i2c_reg_bank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/wo_i2c_regfile_chk.sv
`timescale 1ns/1ps
// Assertion checker for wo_i2c_regfile, attached by bind. Assumes SDA changes
// only while SCL is low, apart from START and STOP conditions.
module wo_i2c_regfile_chk
    import wo_i2c_pkg::*;
#(
    parameter int NREG = 26
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_lvl,
    input logic                   scl_fall,
    input logic                   start_ev,
    input logic                   stop_ev,
    input logic                   sda_drive_low,
    input logic                   wr_en,
    input logic [BYTE_W-1:0]      wr_addr,
    input logic [NREG*BYTE_W-1:0] regs_flat
);
    // R5: acknowledge starts only while SCL is low
    p_ack_rise_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_lvl);

    // R5: acknowledge ends on an SCL fall or a bus condition
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_drive_low) && $past(rst_n)) |-> $past(scl_fall || start_ev || stop_ev));

    // R6: registers move only after a write strobe
    p_no_spurious_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R7: strobe beyond the bank leaves every register unchanged
    p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NREG) |=> $stable(regs_flat));

    // R8: undefined bits stay zero in every register
    for (genvar i = 0; i < NREG; i++) begin : g_mask
        localparam logic [BYTE_W-1:0] KEEP = field_mask(i);
        p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_flat[i*BYTE_W +: BYTE_W] & ~KEEP) == '0);
    end

endmodule

bind wo_i2c_regfile wo_i2c_regfile_chk #(.NREG(NREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_lvl       (scl_lvl),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .regs_flat     (regs_flat)
);

// File: tb/wo_i2c_regfile_test.sv
`timescale 1ns/1ps
// Self-checking bench: bit-banged host, sweeps every address and checks
// acknowledges and register contents against an arithmetic model.
module wo_i2c_regfile_test;
    localparam int NREG = 26;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low;
    logic [NREG*8-1:0] regs_flat;
    logic sda_bus;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_r [NREG];

    assign sda_bus = sda_m & ~sda_drive_low;

    always #2.5 clk = ~clk;

    wo_i2c_regfile uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .regs_flat     (regs_flat)
    );

    // Kept bits per address, taken from requirement R8.
    function automatic logic [7:0] keep_bits(input int a);
        if (a == 0) return 8'hFF;
        if (a == 1 || a == 4) return 8'h9F;
        if (a == 2 || a == 3 || a == 5 || a == 6 || a == 10) return 8'h1F;
        if ((a >= 7 && a <= 9) || (a >= 11 && a <= 22)) return 8'h3F;
        if (a == 23) return 8'hE7;
        if (a == 24 || a == 25) return 8'h8F;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_m = 1'b1; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b0; hold(HALF / 2);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; hold(HALF);
        scl_m = 1'b1; hold(HALF);
        sda_m = 1'b1; hold(4 * HALF);
    endtask

    // Send nbits of b, MSB first; flags any pull-down seen during data bits.
    task automatic send_bits(input logic [7:0] b, input int nbits, output bit leak);
        leak = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; hold(HALF);
            scl_m = 1'b1; hold(HALF / 2);
            if (sda_drive_low) leak = 1'b1;
            hold(HALF / 2);
            scl_m = 1'b0;
        end
    endtask

    // Full byte plus acknowledge clock; checks R5 drive window and release.
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        bit leak;
        logic ack;
        send_bits(b, 8, leak);
        chk(!leak, {"R5 no pull-down during data bits ", tag}, leak, 0);
        sda_m = 1'b1; hold(HALF);
        scl_m = 1'b1; hold(HALF / 2);
        ack = sda_drive_low;
        hold(HALF / 2);
        scl_m = 1'b0; hold(HALF / 2);
        chk(ack == exp_ack, {"ack ", tag}, ack, exp_ack);
        chk(!sda_drive_low, {"R5 release after ninth fall ", tag}, sda_drive_low, 0);
    endtask

    // Frame: device byte, pointer, nbytes data; updates the model on success.
    task automatic xfer(input logic [7:0] devb, input logic [7:0] ptr, input int nbytes,
                        input logic [7:0] seed, input string tag);
        bit good;
        logic [7:0] d;
        logic [7:0] a;
        good = (devb == 8'hEA);
        start_cond();
        send_byte(devb, good, {tag, good ? " R1 device" : " R2 device"});
        send_byte(ptr, good, {tag, " R6 pointer"});
        for (int k = 0; k < nbytes; k++) begin
            d = seed + 8'(k * 37);
            a = ptr + 8'(k);
            send_byte(d, good, {tag, " R6 R7 data"});
            if (good && int'(a) < NREG) exp_r[a] = d & keep_bits(int'(a));
        end
        stop_cond();
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NREG; i++) begin
            chk(regs_flat[i*8 +: 8] == exp_r[i], $sformatf("R10 R8 %s reg %0d", tag, i),
                regs_flat[i*8 +: 8], exp_r[i]);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    endtask

    initial begin
        bit leak;
        clear_model();
        hold(5);
        chk(regs_flat == '0, "R9 registers zero after reset", 0, 0);
        chk(!sda_drive_low, "R9 no pull-down in reset", sda_drive_low, 0);
        rst_n = 1'b1;
        hold(5);

        // Single-byte writes to every address, two patterns each (R6, R8, R10).
        for (int a = 0; a < NREG; a++) begin
            xfer(8'hEA, 8'(a), 1, 8'hFF, "sweep ones");
            check_regs("sweep ones");
            xfer(8'hEA, 8'(a), 1, 8'(8'h5A ^ a), "sweep pattern");
        end
        check_regs("sweep pattern");

        // Burst across the whole bank with pointer increment (R6).
        xfer(8'hEA, 8'h00, NREG, 8'h13, "burst");
        check_regs("R6 burst");

        // Writes running past the end and wholly beyond it (R7).
        xfer(8'hEA, 8'h18, 4, 8'hC3, "R7 tail");
        xfer(8'hEA, 8'h30, 2, 8'h77, "R7 beyond");
        check_regs("R7 after out-of-range");

        // Wrong address and read request are refused (R2).
        xfer(8'hE8, 8'h02, 2, 8'h00, "R2 wrong address");
        xfer(8'hEB, 8'h02, 2, 8'h00, "R2 read bit");
        check_regs("R2 after refused frames");

        // Repeated START abandons the first pointer (R4).
        start_cond();
        send_byte(8'hEA, 1'b1, "R4 first device");
        send_byte(8'h03, 1'b1, "R4 first pointer");
        start_cond();
        send_byte(8'hEA, 1'b1, "R4 second device");
        send_byte(8'h05, 1'b1, "R4 second pointer");
        send_byte(8'hF6, 1'b1, "R4 data");
        stop_cond();
        exp_r[5] = 8'hF6 & 8'h1F;
        check_regs("R4 repeated start");

        // STOP in the middle of a data byte writes nothing (R3).
        start_cond();
        send_byte(8'hEA, 1'b1, "R3 device");
        send_byte(8'h02, 1'b1, "R3 pointer");
        send_bits(8'h00, 4, leak);
        chk(!leak, "R3 no pull-down in partial byte", leak, 0);
        stop_cond();
        check_regs("R3 aborted byte");

        // Reset in mid-run clears everything (R9).
        rst_n = 1'b0;
        hold(3);
        rst_n = 1'b1;
        clear_model();
        hold(2);
        check_regs("R9 reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule